// File: doc/BRIEF.md
# Supply Supervisor Reset Sequencer

This block turns the digital flag of an external supply-voltage comparator into a clean system reset. The flag says the supply sits below its trip level. It is first brought into the clock domain through a two-stage synchronizer. A glitch filter then ignores dips that are too short to matter. The length of dip that is tolerated depends on a second flag that marks a deep overdrive: a deeper drop is allowed only a shorter time before it counts as a brown-out.

Once a brown-out or a power-on event has asserted the reset, the block holds it asserted until the supply has been steadily above the threshold for a long hold-off interval. Any new low reading during that interval starts the interval over. The reset pin is driven push-pull, and a build parameter picks whether it is asserted high or asserted low. All times are parameters counted in clock cycles.

Top module: `rsv_reset_seq`

## Requirements
- R1: While `por` is high the reset output is asserted, and the cycle after `por` is sampled high it is still asserted. With `supply_low` low, the output releases exactly HOLD_CYC+2 rising clock edges after `por` falls.
- R2: With ACTIVE_HIGH=1 the asserted level of `sup_rst` is 1. With ACTIVE_HIGH=0 it is 0. The output is always driven to a two-state level.
- R3: With `deep_dip`=0 and the reset released, a high pulse on `supply_low` lasting at most SHALLOW_CYC clock cycles leaves the output released.
- R4: With `deep_dip`=0, a `supply_low` pulse of SHALLOW_CYC+1 or more cycles asserts the output exactly SHALLOW_CYC+3 rising edges after `supply_low` rises.
- R5: With `deep_dip`=1, a pulse of at most DEEP_CYC cycles is ignored. A pulse of DEEP_CYC+1 cycles asserts the output DEEP_CYC+3 edges after `supply_low` rises.
- R6: While the output is asserted and `supply_low` stays high, the output stays asserted, however long that lasts.
- R7: After a brown-out, the output releases exactly HOLD_CYC+2 rising edges after `supply_low` falls.
- R8: A `supply_low` pulse of any length during the hold-off restarts the full hold-off. The output stays asserted throughout and releases HOLD_CYC+2 edges after the last fall of `supply_low`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| por | input | 1 | Power-on reset, active high, sampled on clock edge |
| supply_low | input | 1 | Comparator flag: supply below trip level (asynchronous) |
| deep_dip | input | 1 | Comparator flag: drop is deep, use the short filter (asynchronous) |
| sup_rst | output | 1 | Push-pull reset output, polarity set by ACTIVE_HIGH |

## Verification
The assertions check several things on every cycle. A filter trip always leads to an asserted reset on the next cycle. An asserted reset never drops while the synchronized flag is low-supply. A release only follows a cycle with the supply good. The filter count clears as soon as the supply reads good, and the hold-off timer never passes its limit. Some behaviour can only be shown by the bench's scenarios, because it spans many cycles across both flags:
- the exact edge counts from an input change to an output change;
- the boundary between a dip that is tolerated and one that trips, for both filter lengths;
- the restart of the hold-off after a late short dip;
- the two polarity builds agreeing.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  function automatic int rsv_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int rsv_bits(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/rsv_sync.sv
module rsv_sync #(
  parameter int WIDTH = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= RST_VAL;
      dout   <= RST_VAL;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end
endmodule

// File: rtl/rsv_dip_filter.sv
module rsv_dip_filter
  import rsv_pkg::*;
#(
  parameter int SHALLOW_CYC = 200,
  parameter int DEEP_CYC    = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic low_s,
  input  logic deep_s,
  output logic trip
);
  localparam int MAXL = rsv_max(SHALLOW_CYC, DEEP_CYC);
  localparam int FW   = rsv_bits(MAXL + 1);
  localparam logic [FW-1:0] LIM_SH  = FW'(SHALLOW_CYC);
  localparam logic [FW-1:0] LIM_DP  = FW'(DEEP_CYC);
  localparam logic [FW-1:0] CNT_TOP = FW'(MAXL);

  logic [FW-1:0] run_len;
  logic [FW-1:0] limit;

  assign limit = deep_s ? LIM_DP : LIM_SH;
  assign trip  = low_s && (run_len >= limit);

  always_ff @(posedge clk) begin
    if (rst)                    run_len <= '0;
    else if (!low_s)            run_len <= '0;
    else if (run_len != CNT_TOP) run_len <= run_len + 1'b1;
  end

  // R3: a good-supply reading ends the current run
  a_r3_run_clears: assert property (@(posedge clk) disable iff (rst)
    !low_s |=> (run_len == '0));
  // R4: a run never passes its saturation value
  a_r4_run_bounded: assert property (@(posedge clk) disable iff (rst)
    run_len <= CNT_TOP);
endmodule

// File: rtl/rsv_holdoff.sv
module rsv_holdoff
  import rsv_pkg::*;
#(
  parameter int HOLD_CYC = 12_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic low_s,
  input  logic trip,
  output logic active
);
  localparam int TW = rsv_bits(HOLD_CYC);
  localparam logic [TW-1:0] T_LAST = TW'(HOLD_CYC - 1);

  logic [TW-1:0] tmr;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b1;
      tmr    <= '0;
    end else if (trip) begin
      active <= 1'b1;
      tmr    <= '0;
    end else if (active) begin
      if (low_s) begin
        tmr <= '0;
      end else if (tmr == T_LAST) begin
        active <= 1'b0;
        tmr    <= '0;
      end else begin
        tmr <= tmr + 1'b1;
      end
    end
  end

  // R4: a filter trip always leaves reset asserted
  a_r4_trip_asserts: assert property (@(posedge clk) disable iff (rst)
    trip |=> active);
  // R6: asserted reset holds while the supply reads low
  a_r6_hold_while_low: assert property (@(posedge clk) disable iff (rst)
    (active && low_s) |=> active);
  // R7: release only follows a good-supply cycle
  a_r7_release_on_good: assert property (@(posedge clk) disable iff (rst)
    $fell(active) |-> !$past(low_s));
  // R8: the hold-off timer stays inside its window
  a_r8_timer_bounded: assert property (@(posedge clk) disable iff (rst)
    tmr <= T_LAST);
endmodule

// File: rtl/rsv_reset_seq.sv
module rsv_reset_seq #(
  parameter int SHALLOW_CYC = 200,
  parameter int DEEP_CYC    = 50,
  parameter int HOLD_CYC    = 12_000_000,
  parameter bit ACTIVE_HIGH = 1'b0
) (
  input  logic clk,
  input  logic por,
  input  logic supply_low,
  input  logic deep_dip,
  output logic sup_rst
);
  logic [1:0] flags_s;
  logic       low_s;
  logic       deep_s;
  logic       trip;
  logic       active;

  // reset value: supply treated as low, shallow filter
  rsv_sync #(.WIDTH(2), .RST_VAL(2'b01)) u_sync (
    .clk  (clk),
    .rst  (por),
    .din  ({deep_dip, supply_low}),
    .dout (flags_s)
  );
  assign low_s  = flags_s[0];
  assign deep_s = flags_s[1];

  rsv_dip_filter #(.SHALLOW_CYC(SHALLOW_CYC), .DEEP_CYC(DEEP_CYC)) u_filt (
    .clk    (clk),
    .rst    (por),
    .low_s  (low_s),
    .deep_s (deep_s),
    .trip   (trip)
  );

  rsv_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk    (clk),
    .rst    (por),
    .low_s  (low_s),
    .trip   (trip),
    .active (active)
  );

  generate
    if (ACTIVE_HIGH) begin : g_pol_hi
      assign sup_rst = active;
    end else begin : g_pol_lo
      assign sup_rst = ~active;
    end
  endgenerate

  // R1: power-on reset leaves the output asserted
  a_r1_por_asserts: assert property (@(posedge clk)
    por |=> (sup_rst == ACTIVE_HIGH));
endmodule

// File: tb/tb_rsv_reset_seq.sv
module tb_rsv_reset_seq;
  localparam int SH   = 12;
  localparam int DP   = 4;
  localparam int HOLD = 40;

  logic clk = 1'b0;
  logic por, supply_low, deep_dip;
  logic rst_lo, rst_hi;
  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rsv_reset_seq #(.SHALLOW_CYC(SH), .DEEP_CYC(DP), .HOLD_CYC(HOLD), .ACTIVE_HIGH(1'b0)) dut (
    .clk(clk), .por(por), .supply_low(supply_low), .deep_dip(deep_dip), .sup_rst(rst_lo));
  rsv_reset_seq #(.SHALLOW_CYC(SH), .DEEP_CYC(DP), .HOLD_CYC(HOLD), .ACTIVE_HIGH(1'b1)) dut_hi (
    .clk(clk), .por(por), .supply_low(supply_low), .deep_dip(deep_dip), .sup_rst(rst_hi));

  function automatic bit asserted();
    return !rst_lo;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // count rising edges until the output reaches the wanted state
  task automatic edges_until(input bit want, input int limit, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (asserted() != want && n < limit);
  endtask

  // R2: both polarity builds must agree
  task automatic check_pol(input string tag);
    check(rst_lo === ~rst_hi, "R2", int'(rst_hi), int'(~rst_lo));
    if (tag.len() == 0) $display("pol");
  endtask

  task automatic t_power_on();
    int n;
    por = 1'b1; supply_low = 1'b1; deep_dip = 1'b0;
    repeat (5) @(negedge clk);
    check(rst_lo === 1'b0, "R1 por level", int'(rst_lo), 0);
    check(rst_hi === 1'b1, "R2 active-high level", int'(rst_hi), 1);
    por = 1'b0; supply_low = 1'b0;
    edges_until(1'b0, HOLD + 20, n);
    check(n == HOLD + 2, "R1 release", n, HOLD + 2);
    check_pol("po");
  endtask

  task automatic t_dip_ignored(input bit deep, input int len, input string req);
    bit seen = 1'b0;
    deep_dip = deep;
    repeat (4) @(negedge clk);
    supply_low = 1'b1;
    repeat (len) @(negedge clk);
    supply_low = 1'b0;
    for (int i = 0; i < len + 10; i++) begin
      @(negedge clk);
      if (asserted() || rst_hi) seen = 1'b1;
    end
    check(!seen, req, int'(seen), 0);
  endtask

  task automatic t_trip(input bit deep, input int lim, input int low_len, input string req);
    int n;
    deep_dip = deep;
    repeat (4) @(negedge clk);
    supply_low = 1'b1;
    edges_until(1'b1, lim + 20, n);
    check(n == lim + 3, req, n, lim + 3);
    check_pol("trip");
    // R6: stays asserted while supply remains low
    for (int i = n; i < low_len; i++) begin
      @(negedge clk);
      if (!asserted()) begin
        check(1'b0, "R6 held during low", 0, 1);
        break;
      end
    end
    check(asserted(), "R6", int'(asserted()), 1);
    supply_low = 1'b0;
    edges_until(1'b0, HOLD + 20, n);
    check(n == HOLD + 2, "R7 release", n, HOLD + 2);
    deep_dip = 1'b0;
  endtask

  task automatic t_restart();
    int n;
    bit dropped = 1'b0;
    deep_dip = 1'b0;
    repeat (4) @(negedge clk);
    supply_low = 1'b1;
    repeat (SH + 8) @(negedge clk);
    supply_low = 1'b0;
    repeat (HOLD - 4) @(negedge clk);
    supply_low = 1'b1;
    repeat (2) @(negedge clk);
    supply_low = 1'b0;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (!asserted() && n < HOLD + 2) dropped = 1'b1;
    end while (asserted() && n < HOLD + 20);
    check(!dropped, "R8 no early release", int'(dropped), 0);
    check(n == HOLD + 2, "R8 restart", n, HOLD + 2);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 20000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_power_on();
    t_dip_ignored(1'b0, SH, "R3 shallow dip at limit");
    t_dip_ignored(1'b0, 3, "R3 short dip");
    t_trip(1'b0, SH, SH + 30, "R4 shallow trip");
    t_dip_ignored(1'b1, DP, "R5 deep dip at limit");
    t_trip(1'b1, DP, DP + 10, "R5 deep trip");
    t_restart();
    check_pol("end");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule